// File: doc/BRIEF.md
# Step Attenuator Parallel Control and Mode Arbiter

This block sits between the control pins of a 6-bit step attenuator and its switched attenuator core. When reset is released it samples a mode strap once and then either obeys a serial programming engine or reads six binary-weighted control lines. In parallel operation, one transparent latch covers both styles of use. Holding the latch-enable input low freezes the state while the lines change, and a high-then-low pulse takes in a new value. Holding latch enable high makes the state follow the lines continuously.

The block also picks the attenuation state applied after reset. That choice depends on both the mode strap and the latch-enable level at reset release. When parallel mode and a high latch enable are captured together, the state is preset from the control lines after a fixed delay of about 4 µs, counted in system clock cycles. The block also decides whether the pin shared between the serial data output and parallel weight bit 3 is driven or left in high impedance.

Top module: `stepatt_par_front`

## Requirements
- R1: Mode is captured from `modeSel` on the first rising clock edge after `rstN` goes high: 1 selects serial, 0 selects parallel. Later changes of `modeSel` have no effect until the next reset.
- R2: `attnOut` is a binary code in 0.5 dB units. Bit 5 weighs 16 dB, bit 4 8 dB, bit 3 4 dB, bit 2 2 dB, bit 1 1 dB and bit 0 0.5 dB. Code 0 is the reference state and code 63 is 31.5 dB. `ctrlIn` bit k maps to `attnOut` bit k.
- R3: In serial mode the default is applied on the second edge after reset release. It is code 0 if `latchEn` was high at capture and code 63 if it was low.
- R4: In parallel mode with `latchEn` low at capture, the default is code 63 on the second edge. It holds until latch enable next goes high.
- R5: In parallel mode, while `latchEn` is low, changes on `ctrlIn` leave `attnOut` unchanged. While `latchEn` is high, `attnOut` takes `ctrlIn` one cycle later. After `latchEn` falls, the last value taken is held.
- R6: In parallel mode with `latchEn` high at capture, `attnValid` stays low and `attnOut` stays 63 for `PRESET_CYC` cycles. Then `attnOut` is loaded from `ctrlIn`. With pulled-up lines (`ctrlIn` = 6'b111000) this gives code 56, which is 28 dB.
- R7: In direct use (latch enable kept high), `attnOut` tracks every change of `ctrlIn` with a latency of one cycle.
- R8: `shareOe` is high only in serial mode, and it is low during reset. `shareOut` equals `serSdo` when `shareOe` is high and 0 otherwise.
- R9: In serial mode, a one-cycle `serLoad` pulse puts `serAttn` on `attnOut` one cycle later, and `ctrlIn` and `latchEn` have no effect. In parallel mode `serLoad` has no effect.
- R10: `attnValid` is low during reset and until the default or preset has been applied. While it is low, `attnOut` is 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | Mode strap: 1 serial, 0 parallel (pulled high off chip) |
| latchEn | input | 1 | Latch enable pin |
| ctrlIn | input | 6 | Weighted parallel control lines, bit 5 = 16 dB |
| serAttn | input | 6 | Attenuation code decoded by the serial engine |
| serLoad | input | 1 | One-cycle strobe from the serial engine: apply `serAttn` |
| serSdo | input | 1 | Serial data output bit from the serial engine |
| attnOut | output | 6 | Attenuation code to the switched array |
| attnValid | output | 1 | Default or preset has been applied |
| serialMode | output | 1 | Captured mode, 1 = serial |
| shareOe | output | 1 | Output enable of the shared serial-out / bit-3 pin |
| shareOut | output | 1 | Data driven on the shared pin |

## Verification
Reset release is the reference point for timing. The mode and the shared-pin enable are due after the first rising edge, and the serial and latched defaults are due after the second. The direct-mode preset is due after edge `PRESET_CYC`+1. In run mode, every pin or strobe change shows on `attnOut` after one edge, and `shareOut` follows `serSdo` in the same cycle. The bench drives inputs on falling edges and waits a counted number of falling edges before sampling each result. In the preset case it samples one edge before the expected load as well as on it, so a load that comes early or late is reported.

// File: rtl/stepatt_pkg.sv
package stepatt_pkg;

  localparam int ATTN_W_DEF = 6;

  // strobes from control to datapath; at most one is high per cycle
  typedef struct packed {
    logic loadMax;
    logic loadRef;
    logic loadPins;
    logic loadSerial;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    PH_CAPTURE = 2'd0,
    PH_DEFAULT = 2'd1,
    PH_PRESET  = 2'd2,
    PH_RUN     = 2'd3
  } phase_t;

endpackage

// File: rtl/stepatt_ctrl.sv
module stepatt_ctrl
  import stepatt_pkg::*;
#(
  parameter int PRESET_CYC = 500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeSel,
  input  logic      latchEn,
  input  logic      serLoad,
  output dpStrobe_t strobe,
  output logic      valid,
  output logic      serMode
);

  localparam int CNT_W = $clog2(PRESET_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESET_CYC - 1);

  phase_t           phase;
  logic             serQ;
  logic             leQ;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_CAPTURE;
      serQ  <= 1'b0;
      leQ   <= 1'b0;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_CAPTURE: begin
          serQ  <= modeSel;
          leQ   <= latchEn;
          cnt   <= '0;
          phase <= (!modeSel && latchEn) ? PH_PRESET : PH_DEFAULT;
        end
        PH_DEFAULT: phase <= PH_RUN;
        PH_PRESET: begin
          if (cnt == CNT_LAST) phase <= PH_RUN;
          else                 cnt   <= cnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    unique case (phase)
      PH_DEFAULT: begin
        strobe.loadRef = serQ && leQ;
        strobe.loadMax = !(serQ && leQ);
      end
      PH_PRESET:  strobe.loadPins = (cnt == CNT_LAST);
      PH_RUN: begin
        strobe.loadPins   = !serQ && latchEn;
        strobe.loadSerial = serQ && serLoad;
      end
      default: ;
    endcase
  end

  assign valid   = (phase == PH_RUN);
  assign serMode = serQ;

endmodule

// File: rtl/stepatt_dp.sv
module stepatt_dp
  import stepatt_pkg::*;
#(
  parameter int ATTN_W = ATTN_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ATTN_W-1:0] ctrlIn,
  input  logic [ATTN_W-1:0] serAttn,
  input  logic              serMode,
  input  logic              serSdo,
  output logic [ATTN_W-1:0] attnOut,
  output logic              shareOe,
  output logic              shareOut
);

  logic [ATTN_W-1:0] attnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   attnQ <= '1;
    else if (strobe.loadMax)     attnQ <= '1;
    else if (strobe.loadRef)     attnQ <= '0;
    else if (strobe.loadPins)    attnQ <= ctrlIn;
    else if (strobe.loadSerial)  attnQ <= serAttn;
  end

  assign attnOut  = attnQ;
  assign shareOe  = serMode;
  assign shareOut = serMode & serSdo;

endmodule

// File: rtl/stepatt_par_front.sv
module stepatt_par_front
  import stepatt_pkg::*;
#(
  parameter int ATTN_W    = ATTN_W_DEF,
  parameter int CLK_HZ    = 125_000_000,
  parameter int PRESET_NS = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              latchEn,
  input  logic [ATTN_W-1:0] ctrlIn,
  input  logic [ATTN_W-1:0] serAttn,
  input  logic              serLoad,
  input  logic              serSdo,
  output logic [ATTN_W-1:0] attnOut,
  output logic              attnValid,
  output logic              serialMode,
  output logic              shareOe,
  output logic              shareOut
);

  localparam longint RAW_CYC    = (longint'(CLK_HZ) * longint'(PRESET_NS)) / 64'd1_000_000_000;
  localparam int     PRESET_CYC = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);

  dpStrobe_t strobe;
  logic      serMode;

  stepatt_ctrl #(.PRESET_CYC(PRESET_CYC)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .latchEn (latchEn),
    .serLoad (serLoad),
    .strobe  (strobe),
    .valid   (attnValid),
    .serMode (serMode)
  );

  stepatt_dp #(.ATTN_W(ATTN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ctrlIn   (ctrlIn),
    .serAttn  (serAttn),
    .serMode  (serMode),
    .serSdo   (serSdo),
    .attnOut  (attnOut),
    .shareOe  (shareOe),
    .shareOut (shareOut)
  );

  assign serialMode = serMode;

endmodule

// File: rtl/stepatt_par_front_chk.sv
module stepatt_par_front_chk #(
  parameter int ATTN_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              latchEn,
  input logic [ATTN_W-1:0] ctrlIn,
  input logic              serLoad,
  input logic [ATTN_W-1:0] serAttn,
  input logic              serSdo,
  input logic [ATTN_W-1:0] attnOut,
  input logic              attnValid,
  input logic              serialMode,
  input logic              shareOe,
  input logic              shareOut
);

  // R10: before the default is applied the array sits at maximum attenuation
  a_r10_invalid_max: assert property (@(posedge clk) disable iff (!rstN)
    !attnValid |-> attnOut == '1);

  // R8: the shared pin is quiet whenever it is not driven
  a_r8_par_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !shareOe |-> !shareOut);

  // R8: when driven, the pin carries the serial data bit
  a_r8_ser_pass: assert property (@(posedge clk) disable iff (!rstN)
    shareOe |-> shareOut == serSdo);

  // R1: once valid, the captured mode never moves
  a_r1_mode_stable: assert property (@(posedge clk) disable iff (!rstN)
    attnValid |=> $stable(serialMode));

  // R5: latch closed in parallel mode keeps the state
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (attnValid && $past(attnValid) && !serialMode && !$past(latchEn)) |-> $stable(attnOut));

  // R7: latch open in parallel mode follows the lines one cycle later
  a_r7_follow: assert property (@(posedge clk) disable iff (!rstN)
    (attnValid && $past(attnValid) && !serialMode && $past(latchEn)) |-> attnOut == $past(ctrlIn));

  // R9: serial mode changes state only on a load strobe
  a_r9_ser_only: assert property (@(posedge clk) disable iff (!rstN)
    (attnValid && $past(attnValid) && serialMode) |->
      (attnOut == ($past(serLoad) ? $past(serAttn) : $past(attnOut))));

endmodule

bind stepatt_par_front stepatt_par_front_chk #(.ATTN_W(ATTN_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .latchEn    (latchEn),
  .ctrlIn     (ctrlIn),
  .serLoad    (serLoad),
  .serAttn    (serAttn),
  .serSdo     (serSdo),
  .attnOut    (attnOut),
  .attnValid  (attnValid),
  .serialMode (serialMode),
  .shareOe    (shareOe),
  .shareOut   (shareOut)
);

// File: tb/stepatt_par_front_bench.sv
`timescale 1ns/1ps
module stepatt_par_front_bench;

  localparam int PRESET_CYC = 500;  // 125 MHz x 4 us

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSel = 1'b1;
  logic       latchEn = 1'b0;
  logic [5:0] ctrlIn = '0;
  logic [5:0] serAttn = '0;
  logic       serLoad = 1'b0;
  logic       serSdo = 1'b0;
  logic [5:0] attnOut;
  logic       attnValid;
  logic       serialMode;
  logic       shareOe;
  logic       shareOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stepatt_par_front u_stepatt_par_front (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .latchEn(latchEn),
    .ctrlIn(ctrlIn), .serAttn(serAttn), .serLoad(serLoad), .serSdo(serSdo),
    .attnOut(attnOut), .attnValid(attnValid), .serialMode(serialMode),
    .shareOe(shareOe), .shareOut(shareOut)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // holds reset, checks the reset state, releases on a falling edge
  task automatic doReset(logic m, logic le, logic [5:0] lines);
    @(negedge clk);
    rstN = 1'b0; modeSel = m; latchEn = le; ctrlIn = lines;
    serLoad = 1'b0; serSdo = 1'b1;
    cyc(3);
    chk("R10 valid low in reset", int'(attnValid), 0);
    chk("R10 max in reset", int'(attnOut), 63);
    chk("R8 oe low in reset", int'(shareOe), 0);
    rstN = 1'b1;
  endtask

  task automatic t_serial_le_high();
    doReset(1'b1, 1'b1, 6'd0);
    cyc(1);
    chk("R1 serial captured", int'(serialMode), 1);
    chk("R8 oe serial", int'(shareOe), 1);
    chk("R10 not yet valid", int'(attnValid), 0);
    cyc(1);
    chk("R3 valid", int'(attnValid), 1);
    chk("R3 reference default", int'(attnOut), 0);
    serSdo = 1'b1; #1;
    chk("R8 sdo high passes", int'(shareOut), 1);
    serSdo = 1'b0; #1;
    chk("R8 sdo low passes", int'(shareOut), 0);
    @(negedge clk);
    latchEn = 1'b1; ctrlIn = 6'd5;
    cyc(2);
    chk("R9 pins ignored in serial", int'(attnOut), 0);
    serLoad = 1'b1; serAttn = 6'd37;
    cyc(1);
    serLoad = 1'b0; serAttn = 6'd12;
    chk("R9 serial load", int'(attnOut), 37);
    cyc(2);
    chk("R9 no load without strobe", int'(attnOut), 37);
    modeSel = 1'b0;
    cyc(2);
    chk("R1 mode change ignored", int'(serialMode), 1);
    chk("R1 oe unchanged", int'(shareOe), 1);
  endtask

  task automatic t_serial_le_low();
    doReset(1'b1, 1'b0, 6'd9);
    cyc(2);
    chk("R3 valid", int'(attnValid), 1);
    chk("R3 max default", int'(attnOut), 63);
  endtask

  task automatic t_latched();
    doReset(1'b0, 1'b0, 6'd0);
    cyc(1);
    chk("R1 parallel captured", int'(serialMode), 0);
    cyc(1);
    chk("R4 valid", int'(attnValid), 1);
    chk("R4 max default", int'(attnOut), 63);
    serSdo = 1'b1; #1;
    chk("R8 oe low parallel", int'(shareOe), 0);
    chk("R8 out quiet parallel", int'(shareOut), 0);
    @(negedge clk);
    ctrlIn = 6'd21;
    cyc(3);
    chk("R5 closed latch holds", int'(attnOut), 63);
    serLoad = 1'b1; serAttn = 6'd9;
    cyc(1);
    serLoad = 1'b0;
    cyc(1);
    chk("R9 serial strobe ignored", int'(attnOut), 63);
    latchEn = 1'b1;
    cyc(1);
    latchEn = 1'b0;
    chk("R5 latch takes lines", int'(attnOut), 21);
    ctrlIn = 6'd42;
    cyc(2);
    chk("R5 held after fall", int'(attnOut), 21);
    for (int k = 0; k < 6; k++) begin
      ctrlIn = 6'(1 << k); latchEn = 1'b1;
      cyc(1);
      latchEn = 1'b0;
      chk($sformatf("R2 weight bit %0d", k), int'(attnOut), 1 << k);
    end
    ctrlIn = 6'h3f; latchEn = 1'b1;
    cyc(1);
    latchEn = 1'b0;
    chk("R2 all lines high", int'(attnOut), 63);
    modeSel = 1'b1;
    cyc(2);
    chk("R1 parallel kept", int'(shareOe), 0);
  endtask

  task automatic t_direct(logic [5:0] lines, string tag);
    doReset(1'b0, 1'b1, lines);
    cyc(PRESET_CYC);
    chk({"R6 not valid before preset ", tag}, int'(attnValid), 0);
    chk({"R6 max before preset ", tag}, int'(attnOut), 63);
    cyc(1);
    chk({"R6 valid after preset ", tag}, int'(attnValid), 1);
    chk({"R6 preset value ", tag}, int'(attnOut), int'(lines));
  endtask

  task automatic t_direct_track();
    t_direct(6'b111000, "28dB");
    ctrlIn = 6'd13;
    cyc(1);
    chk("R7 track 13", int'(attnOut), 13);
    ctrlIn = 6'd50;
    cyc(1);
    chk("R7 track 50", int'(attnOut), 50);
    t_direct(6'b000101, "other");
  endtask

  initial begin
    t_serial_le_high();
    t_serial_le_low();
    t_latched();
    t_direct_track();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule